// File: doc/BRIEF.md
# Serial-Loaded Single Lamp Selector

This block lights one lamp at a time out of a bank of lamp outputs. The lamp number comes from a byte that the processor places in its clocked-serial transmit register. This project models that register as a plain byte load. The number takes effect only when the processor later writes a sample to its parallel output port. On that write, the previously lit lamp goes dark and the addressed lamp turns on. The same write also sends the sample, with its bits mirrored, to an 8-bit unsigned audio DAC register.

The top bit of the held byte is a "fresh number" flag and is dropped before the number is used. Numbers past the last game lamp never light a stray lamp. If the flag is set, the lamp already recorded as current is lit again. If the flag is clear, the lamp outputs are left exactly as they were. The highest lamp output is reserved for an operator lamp that is driven elsewhere, so this block always holds it low.

Top module: `lamp_sel_top`

## Requirements
- R1: During and after reset, every lamp output is 0, the DAC output is 8'h80 and the recorded current lamp number is 0.
- R2: A byte load (`idx_load` high) stores `idx_byte` for later writes. By itself it changes neither the lamp outputs nor the DAC output.
- R3: On a sample write (`smp_wr` high), if bit 7 of the held byte is 1 and bits 6:0 are 36 or less, the lamp with number bits 6:0 is lit one clock later, all other lamps are off, and that number becomes the current lamp.
- R4: On a sample write where bit 7 of the held byte is 1 and bits 6:0 exceed 36, only the current lamp is lit one clock later, and the current number is kept. Directly after reset, this lights lamp 0.
- R5: On a sample write where bit 7 of the held byte is 0 and its value is 36 or less, that value is used directly as the lamp number, as in R3.
- R6: On a sample write where bit 7 of the held byte is 0 and its value exceeds 36, the lamp outputs and the current number do not change.
- R7: At most one lamp output is 1 at any time, and the reserved top output, `lamp_vec[37]`, is always 0.
- R8: On every sample write, one clock later, `dac_out[k]` equals bit 7-k of `smp_data`.
- R9: In a cycle without a sample write, `dac_out` and `lamp_vec` keep their values at the next clock.
- R10: When a byte load and a sample write happen in the same cycle, the write uses the byte that was held before that cycle. The new byte serves the following writes.
- R11: Repeated sample writes with no new load reuse the same held byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| idx_load | input | 1 | Stores `idx_byte` as the held lamp byte |
| idx_byte | input | 8 | Lamp byte from the serial transmit register |
| smp_wr | input | 1 | Parallel-port sample write strobe; commits the lamp and the DAC value |
| smp_data | input | 8 | Sample byte written to the port |
| lamp_vec | output | 38 | Lamp outputs, one bit per lamp; bit 37 reserved |
| dac_out | output | 8 | Mirrored sample for the audio DAC |

## Verification
The assertions watch properties that must hold on every clock:
- at most one lamp is lit, and the reserved output stays low;
- outputs do not move without a write;
- an unflagged out-of-range write leaves the lamps frozen;
- a flagged out-of-range write lights exactly the current lamp;
- an in-range write lights its lamp;
- the DAC's end bits arrive mirrored.

Other behaviour only the bench's scenarios can show, because it depends on history across writes:
- which lamp is current after a sequence of writes;
- lamp 0 being relit right after reset;
- the ordering between a load and a write in the same cycle;
- reuse of a stale byte;
- the full mirrored value for varied data patterns.

// File: rtl/lamp_sel_pkg.sv
package lamp_sel_pkg;

  // Mirror a byte: output bit k takes input bit 7-k.
  function automatic logic [7:0] mirror_byte(input logic [7:0] d);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[k] = d[7-k];
    return r;
  endfunction

  // True when a stripped lamp number addresses a real game lamp.
  function automatic logic num_in_range(input logic [6:0] num, input logic [6:0] top);
    return num <= top;
  endfunction

endpackage

// File: rtl/lamp_sel_hold.sv
module lamp_sel_hold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [BYTE_W-1:0] hold_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_o <= '0;
    else if (load_i) hold_o <= byte_i;
  end

  // R2: the held byte moves only on a load
  a_r2_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(hold_o));
endmodule

// File: rtl/lamp_sel_tracker.sv
module lamp_sel_tracker
  import lamp_sel_pkg::*;
#(
  parameter int NUM_LAMPS = 38,
  parameter int BYTE_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 commit_i,
  input  logic [BYTE_W-1:0]    hold_i,
  output logic [NUM_LAMPS-1:0] lamps_o
);
  localparam int NUM_W   = BYTE_W - 1;
  localparam int SEL_W   = $clog2(NUM_LAMPS);
  localparam int MAX_IDX = NUM_LAMPS - 2;

  // Named internal events
  logic             fresh_flag;
  logic [NUM_W-1:0] cand_num;
  logic             cand_ok;
  logic             relight_ev;
  logic             move_ev;
  logic             upd_ev;
  logic [SEL_W-1:0] cur_q;
  logic [SEL_W-1:0] next_sel;

  assign fresh_flag = hold_i[BYTE_W-1];
  assign cand_num   = hold_i[NUM_W-1:0];
  assign cand_ok    = num_in_range(cand_num, NUM_W'(MAX_IDX));
  assign move_ev    = commit_i && cand_ok;
  assign relight_ev = commit_i && !cand_ok && fresh_flag;
  assign upd_ev     = move_ev || relight_ev;
  assign next_sel   = cand_ok ? cand_num[SEL_W-1:0] : cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cur_q <= '0;
    else if (move_ev) cur_q <= cand_num[SEL_W-1:0];
  end

  for (genvar i = 0; i < NUM_LAMPS; i++) begin : g_lamp
    if (i < NUM_LAMPS - 1) begin : g_game
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lamps_o[i] <= 1'b0;
        else if (upd_ev) lamps_o[i] <= (next_sel == SEL_W'(i));
      end
    end else begin : g_reserved
      assign lamps_o[i] = 1'b0;
    end
  end

  // R7
  a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lamps_o));
  a_r7_reserved_low: assert property (@(posedge clk) disable iff (!rst_n)
    !lamps_o[NUM_LAMPS-1]);
  // R3 / R5
  a_r3_lamp_lit: assert property (@(posedge clk) disable iff (!rst_n)
    move_ev |=> lamps_o[cur_q] && $countones(lamps_o) == 1);
  // R4
  a_r4_relight: assert property (@(posedge clk) disable iff (!rst_n)
    relight_ev |=> $stable(cur_q) && lamps_o[cur_q] && $countones(lamps_o) == 1);
  // R6
  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i && !cand_ok && !fresh_flag |=> $stable(lamps_o) && $stable(cur_q));
  // R9
  a_r9_lamps_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(lamps_o) && $stable(cur_q));
endmodule

// File: rtl/lamp_sel_dac.sv
module lamp_sel_dac
  import lamp_sel_pkg::*;
#(
  parameter logic [7:0] DAC_RESET = 8'h80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [7:0] data_i,
  output logic [7:0] dac_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dac_o <= DAC_RESET;
    else if (wr_i) dac_o <= mirror_byte(data_i);
  end

  // R8: the end bits swap places
  a_r8_ends_swapped: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> dac_o[0] == $past(data_i[7]) && dac_o[7] == $past(data_i[0]));
  // R9
  a_r9_dac_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(dac_o));
endmodule

// File: rtl/lamp_sel_top.sv
module lamp_sel_top #(
  parameter int         NUM_LAMPS = 38,
  parameter logic [7:0] DAC_RESET = 8'h80
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 idx_load,
  input  logic [7:0]           idx_byte,
  input  logic                 smp_wr,
  input  logic [7:0]           smp_data,
  output logic [NUM_LAMPS-1:0] lamp_vec,
  output logic [7:0]           dac_out
);
  localparam int BYTE_W = 8;

  logic [BYTE_W-1:0] held_byte;

  lamp_sel_hold #(.BYTE_W(BYTE_W)) hold_i (
    .clk(clk), .rst_n(rst_n), .load_i(idx_load), .byte_i(idx_byte), .hold_o(held_byte)
  );

  lamp_sel_tracker #(.NUM_LAMPS(NUM_LAMPS), .BYTE_W(BYTE_W)) track_i (
    .clk(clk), .rst_n(rst_n), .commit_i(smp_wr), .hold_i(held_byte), .lamps_o(lamp_vec)
  );

  lamp_sel_dac #(.DAC_RESET(DAC_RESET)) dac_i (
    .clk(clk), .rst_n(rst_n), .wr_i(smp_wr), .data_i(smp_data), .dac_o(dac_out)
  );

  // R2: a lone load leaves both outputs untouched
  a_r2_load_silent: assert property (@(posedge clk) disable iff (!rst_n)
    idx_load && !smp_wr |=> $stable(lamp_vec) && $stable(dac_out));
endmodule

// File: tb/lamp_sel_top_tb_top.sv
module lamp_sel_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        idx_load = 1'b0;
  logic [7:0]  idx_byte = '0;
  logic        smp_wr = 1'b0;
  logic [7:0]  smp_data = '0;
  logic [37:0] lamp_vec;
  logic [7:0]  dac_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model state
  int          m_hold = 0;
  int          m_cur = 0;
  logic [37:0] m_lamps = '0;
  logic [7:0]  m_dac = 8'h80;

  always #10 clk = ~clk;

  lamp_sel_top dut_i (
    .clk(clk), .rst_n(rst_n), .idx_load(idx_load), .idx_byte(idx_byte),
    .smp_wr(smp_wr), .smp_data(smp_data), .lamp_vec(lamp_vec), .dac_out(dac_out)
  );

  task automatic compare(input string tag);
    checks++;
    if (lamp_vec !== m_lamps) begin
      errors++;
      $display("FAIL %s lamps actual %h expected %h", tag, lamp_vec, m_lamps);
    end
    checks++;
    if (dac_out !== m_dac) begin
      errors++;
      $display("FAIL %s dac actual %h expected %h", tag, dac_out, m_dac);
    end
    checks++;
    if (lamp_vec[37] !== 1'b0 || $countones(lamp_vec) > 1) begin
      errors++;
      $display("FAIL R7 lamps actual %h expected at most one bit, bit 37 low", lamp_vec);
    end
  endtask

  // Behavioural next state: the write uses the byte held before this cycle
  task automatic model(input logic ld, input logic [7:0] lb, input logic wr, input logic [7:0] wd);
    if (wr) begin
      int num;
      num = m_hold % 128;
      if (num <= 36) begin
        m_cur = num;
        m_lamps = '0;
        m_lamps[num] = 1'b1;
      end else if (m_hold >= 128) begin
        m_lamps = '0;
        m_lamps[m_cur] = 1'b1;
      end
      for (int k = 0; k < 8; k++) m_dac[k] = wd[7-k];
    end
    if (ld) m_hold = lb;
  endtask

  task automatic step(input logic ld, input logic [7:0] lb, input logic wr,
                      input logic [7:0] wd, input string tag);
    idx_load = ld; idx_byte = lb; smp_wr = wr; smp_data = wd;
    model(ld, lb, wr, wd);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");
    // R2: load alone changes nothing
    step(1, 8'hFF, 0, 8'h00, "R2");
    step(0, 8'h00, 0, 8'h00, "R2");
    // R4: flagged 127 right after reset lights lamp 0
    step(0, 8'h00, 1, 8'h01, "R4");
    // R3: flagged 5
    step(1, 8'h85, 0, 8'h00, "R3");
    step(0, 8'h00, 1, 8'h80, "R3");
    // R4: flagged 40 keeps lamp 5
    step(1, 8'hA8, 0, 8'h00, "R4");
    step(0, 8'h00, 1, 8'hF0, "R4");
    // R3 boundary: flagged 36
    step(1, 8'hA4, 1, 8'h5A, "R10");
    step(0, 8'h00, 1, 8'h3C, "R3");
    // R6: unflagged 37 freezes lamps
    step(1, 8'h25, 0, 8'h00, "R6");
    step(0, 8'h00, 1, 8'h12, "R6");
    // R5: unflagged 0 and 36
    step(1, 8'h00, 1, 8'hC3, "R5");
    step(0, 8'h00, 1, 8'h07, "R5");
    step(1, 8'h24, 0, 8'h00, "R5");
    step(0, 8'h00, 1, 8'hE1, "R5");
    // R6: unflagged 127
    step(1, 8'h7F, 1, 8'h99, "R6");
    step(0, 8'h00, 1, 8'h66, "R6");
    // R10: same-cycle load and write uses the old byte
    step(1, 8'h8B, 1, 8'h01, "R10");
    step(0, 8'h00, 1, 8'h02, "R10");
    // R11: repeated writes reuse held byte
    step(1, 8'h90, 0, 8'h00, "R11");
    for (int i = 0; i < 4; i++) step(0, 8'h00, 1, 8'(i * 37 + 11), "R11");
    // R9: idle cycles hold everything
    for (int i = 0; i < 5; i++) step(0, 8'h00, 0, 8'hAA, "R9");
    // R8: DAC mirroring over varied data
    for (int i = 0; i < 24; i++) step(0, 8'h00, 1, 8'(i * 53 + 7), "R8");
    // R3: walk several flagged numbers
    for (int i = 0; i < 37; i += 6) begin
      step(1, 8'(128 + i), 0, 8'h00, "R3");
      step(0, 8'h00, 1, 8'(i), "R3");
    end
    // R1: reset again mid-run
    rst_n = 1'b0;
    m_hold = 0; m_cur = 0; m_lamps = '0; m_dac = 8'h80;
    @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    step(1, 8'hC8, 0, 8'h00, "R1");
    step(0, 8'h00, 1, 8'h00, "R4");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule